// File: doc/BRIEF.md
# Branch Target Stream Cache

This block sits beside the fetch unit and remembers, for each recently taken branch, the first few instruction words found at the branch destination. When fetch presents the address of a branch it has already met, the block answers on the next clock with a hit flag, up to four ready-to-issue instruction words and how many of them are usable. Fetch can then load the instruction queue one cycle earlier than a trip through the instruction cache would allow, while it starts the normal fetch of the following words.

Storage is 128 entries organised as 32 sets of four ways. The set comes from the branch word address and the rest of the address forms the tag. Entries are written through an allocate port whenever a taken branch in a loop or branch sequence resolves. Choice of way inside a set is made internally with a three-bit tree pseudo-LRU per set. A single flush input empties the whole structure in one cycle, for example after code has been rewritten.

Top module: `tgt_stream_cache`

## Requirements
- R1: The set index is address bits [6:2] and the tag is bits [31:7]; bits [1:0] take no part in matching, and entries in different sets never interfere.
- R2: A lookup presented with lkp_valid high yields its result on the outputs in the next cycle only; in any cycle not directly after a lookup, rsp_hit is 0.
- R3: On a hit, rsp_count gives the stored count (1 to 4) and rsp_words lane k (bits [32k+31:32k], lane 0 being the first target word) carries stored word k for k below the count, with every lane at or above the count reading zero.
- R4: On a miss, rsp_hit, rsp_count and rsp_words are all zero.
- R5: An allocation whose tag is already present in its set overwrites that way; otherwise it fills the lowest-numbered invalid way; with no invalid way it replaces the pseudo-LRU victim.
- R6: A set never holds two valid entries with the same tag.
- R7: Each set keeps three bits: b0 picks the half (0 = ways 0/1, 1 = ways 2/3), b1 picks way 0 (0) or 1 (1), b2 picks way 2 (0) or 3 (1). A lookup hit or an allocation on a way points these bits away from it, the allocation applied last when both touch one set; reset and flush clear all bits to zero.
- R8: A flush invalidates every entry at the next edge; a lookup in the flush cycle misses and an allocation in the flush cycle is dropped.
- R9: An allocation with a count of 0 or above 4 is ignored.
- R10: A lookup and an allocation in the same cycle see the contents as they were before that allocation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_valid | input | 1 | Lookup request this cycle |
| lkp_addr | input | 32 | Branch address to look up |
| rsp_hit | output | 1 | Registered lookup hit |
| rsp_count | output | 3 | Number of usable target words on a hit |
| rsp_words | output | 128 | Four target words, lane 0 in the low bits |
| alloc_valid | input | 1 | Write an entry this cycle |
| alloc_addr | input | 32 | Branch address of the entry |
| alloc_words | input | 128 | Target words to store, lane 0 in the low bits |
| alloc_count | input | 3 | Number of valid target words, 1 to 4 |
| flush | input | 1 | Invalidate all entries |

## Verification
Checked on every cycle by properties: the response is quiet when no lookup preceded it, a hit reports a count between one and four and a miss drives all zeros, no tag ever matches two ways of one set, a flush leaves every valid bit clear and turns the simultaneous lookup into a miss, and each touch moves the set's victim off the way just used. Only the directed scenarios can show that the right words come back masked to the right lane count, that a full set evicts exactly the way the tree names (with and without an intervening hit), that rewriting a present address does not consume a second way, and that a same-cycle write stays invisible to the lookup beside it.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  localparam int TSC_WAYS  = 4;
  localparam int TSC_LANES = 4;
  localparam int TSC_CNT_W = 3;

  typedef logic [2:0] plru_t;
  typedef logic [1:0] way_t;

  // Point the tree away from the way just used.
  function automatic plru_t plru_touch(plru_t s, way_t w);
    plru_t n;
    n = s;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  // Follow the tree to the way to replace.
  function automatic way_t plru_victim(plru_t s);
    if (!s[0]) return {1'b0, s[1]};
    return {1'b1, s[2]};
  endfunction

  // Lowest-numbered set bit of a free mask.
  function automatic way_t first_free(logic [TSC_WAYS-1:0] free);
    way_t r;
    r = '0;
    for (int i = TSC_WAYS - 1; i >= 0; i--) begin
      if (free[i]) r = way_t'(i);
    end
    return r;
  endfunction

  function automatic logic count_ok(logic [TSC_CNT_W-1:0] c);
    return (c != '0) && (int'(c) <= TSC_LANES);
  endfunction

endpackage

// File: rtl/tsc_way_store.sv
module tsc_way_store
  import tsc_pkg::*;
#(
  parameter int SETS   = 32,
  parameter int IDX_W  = 5,
  parameter int TAG_W  = 25,
  parameter int DATA_W = 128
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [TAG_W-1:0]     wr_tag,
  input  logic [TSC_CNT_W-1:0] wr_cnt,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [IDX_W-1:0]     rd_a_idx,
  output logic                 rd_a_valid,
  output logic [TAG_W-1:0]     rd_a_tag,
  output logic [TSC_CNT_W-1:0] rd_a_cnt,
  output logic [DATA_W-1:0]    rd_a_data,
  input  logic [IDX_W-1:0]     rd_b_idx,
  output logic                 rd_b_valid,
  output logic [TAG_W-1:0]     rd_b_tag
);

  logic [SETS-1:0]      vld_q;
  logic [TAG_W-1:0]     tag_q  [SETS];
  logic [TSC_CNT_W-1:0] cnt_q  [SETS];
  logic [DATA_W-1:0]    data_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      vld_q <= '0;
    end else if (wr_en) begin
      vld_q[wr_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      cnt_q[wr_idx]  <= wr_cnt;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_a_valid = vld_q[rd_a_idx];
  assign rd_a_tag   = tag_q[rd_a_idx];
  assign rd_a_cnt   = cnt_q[rd_a_idx];
  assign rd_a_data  = data_q[rd_a_idx];
  assign rd_b_valid = vld_q[rd_b_idx];
  assign rd_b_tag   = tag_q[rd_b_idx];

  // R8: one cycle after a flush nothing in this way is valid
  p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld_q == '0));

endmodule

// File: rtl/tsc_tag_match.sv
module tsc_tag_match
  import tsc_pkg::*;
#(
  parameter int TAG_W = 25
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [TSC_WAYS-1:0]             way_vld,
  input  logic [TSC_WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [TAG_W-1:0]                key,
  output logic [TSC_WAYS-1:0]             hit_vec,
  output logic                            any_hit,
  output way_t                            hit_way
);

  for (genvar w = 0; w < TSC_WAYS; w++) begin : g_cmp
    assign hit_vec[w] = way_vld[w] && (way_tag[w] == key);
  end

  assign any_hit = |hit_vec;

  always_comb begin
    hit_way = '0;
    for (int w = 0; w < TSC_WAYS; w++) begin
      if (hit_vec[w]) hit_way = way_t'(w);
    end
  end

  // R6: never two valid copies of one tag in a set
  p_single_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/tsc_plru_bank.sv
module tsc_plru_bank
  import tsc_pkg::*;
#(
  parameter int SETS  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             a_en,
  input  logic [IDX_W-1:0] a_idx,
  input  way_t             a_way,
  input  logic             b_en,
  input  logic [IDX_W-1:0] b_idx,
  input  way_t             b_way,
  input  logic [IDX_W-1:0] rd_idx,
  output way_t             rd_victim
);

  plru_t st_q [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int s = 0; s < SETS; s++) st_q[s] <= '0;
    end else if (a_en && b_en && (a_idx == b_idx)) begin
      st_q[a_idx] <= plru_touch(plru_touch(st_q[a_idx], a_way), b_way);
    end else begin
      if (a_en) st_q[a_idx] <= plru_touch(st_q[a_idx], a_way);
      if (b_en) st_q[b_idx] <= plru_touch(st_q[b_idx], b_way);
    end
  end

  assign rd_victim = plru_victim(st_q[rd_idx]);

  // R7: after an allocation the set no longer names that way as victim
  p_victim_moves_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (b_en && !flush) |=> (plru_victim(st_q[$past(b_idx)]) != $past(b_way)));

endmodule

// File: rtl/tgt_stream_cache.sv
module tgt_stream_cache
  import tsc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int INSN_W = 32,
  parameter int SETS   = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          lkp_valid,
  input  logic [ADDR_W-1:0]             lkp_addr,
  output logic                          rsp_hit,
  output logic [TSC_CNT_W-1:0]          rsp_count,
  output logic [TSC_LANES*INSN_W-1:0]   rsp_words,
  input  logic                          alloc_valid,
  input  logic [ADDR_W-1:0]             alloc_addr,
  input  logic [TSC_LANES*INSN_W-1:0]   alloc_words,
  input  logic [TSC_CNT_W-1:0]          alloc_count,
  input  logic                          flush
);

  localparam int IDX_W  = $clog2(SETS);
  localparam int IDX_LO = 2;
  localparam int TAG_LO = IDX_LO + IDX_W;
  localparam int TAG_W  = ADDR_W - TAG_LO;
  localparam int DATA_W = TSC_LANES * INSN_W;

  // Keep lanes below the count, zero the rest.
  function automatic logic [DATA_W-1:0] keep_lanes(logic [DATA_W-1:0] d,
                                                   logic [TSC_CNT_W-1:0] c);
    logic [DATA_W-1:0] r;
    r = '0;
    for (int l = 0; l < TSC_LANES; l++) begin
      if (l < int'(c)) r[l*INSN_W +: INSN_W] = d[l*INSN_W +: INSN_W];
    end
    return r;
  endfunction

  // Address split
  logic [IDX_W-1:0] lk_idx, al_idx;
  logic [TAG_W-1:0] lk_tag, al_tag;
  logic [3:0]       unused_low_bits;

  assign lk_idx = lkp_addr[TAG_LO-1:IDX_LO];
  assign lk_tag = lkp_addr[ADDR_W-1:TAG_LO];
  assign al_idx = alloc_addr[TAG_LO-1:IDX_LO];
  assign al_tag = alloc_addr[ADDR_W-1:TAG_LO];
  assign unused_low_bits = {lkp_addr[1:0], alloc_addr[1:0]};

  // Way reads
  logic [TSC_WAYS-1:0]            lk_vld, al_vld;
  logic [TSC_WAYS-1:0][TAG_W-1:0] lk_tags, al_tags;
  logic [TSC_CNT_W-1:0]           lk_cnt  [TSC_WAYS];
  logic [DATA_W-1:0]              lk_data [TSC_WAYS];
  logic [TSC_WAYS-1:0]            wr_en;

  // Named internal events
  logic                lk_hit;      // lookup found a valid entry and is not flushed
  logic                lk_any;
  way_t                lk_way;
  logic [TSC_WAYS-1:0] lk_vec;
  logic                al_ok;       // allocation will be written
  logic                al_hit;      // allocation address already present
  way_t                al_hit_way;
  logic [TSC_WAYS-1:0] al_vec;
  logic                al_has_free;
  way_t                al_victim;
  way_t                al_way;      // way chosen for the write

  for (genvar w = 0; w < TSC_WAYS; w++) begin : g_way
    assign wr_en[w] = al_ok && (al_way == way_t'(w));

    tsc_way_store #(
      .SETS   (SETS),
      .IDX_W  (IDX_W),
      .TAG_W  (TAG_W),
      .DATA_W (DATA_W)
    ) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .flush      (flush),
      .wr_en      (wr_en[w]),
      .wr_idx     (al_idx),
      .wr_tag     (al_tag),
      .wr_cnt     (alloc_count),
      .wr_data    (alloc_words),
      .rd_a_idx   (lk_idx),
      .rd_a_valid (lk_vld[w]),
      .rd_a_tag   (lk_tags[w]),
      .rd_a_cnt   (lk_cnt[w]),
      .rd_a_data  (lk_data[w]),
      .rd_b_idx   (al_idx),
      .rd_b_valid (al_vld[w]),
      .rd_b_tag   (al_tags[w])
    );
  end

  tsc_tag_match #(.TAG_W(TAG_W)) u_lk_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .way_vld (lk_vld),
    .way_tag (lk_tags),
    .key     (lk_tag),
    .hit_vec (lk_vec),
    .any_hit (lk_any),
    .hit_way (lk_way)
  );

  tsc_tag_match #(.TAG_W(TAG_W)) u_al_match (
    .clk     (clk),
    .rst_n   (rst_n),
    .way_vld (al_vld),
    .way_tag (al_tags),
    .key     (al_tag),
    .hit_vec (al_vec),
    .any_hit (al_hit),
    .hit_way (al_hit_way)
  );

  assign lk_hit      = lkp_valid && lk_any && !flush;
  assign al_ok       = alloc_valid && !flush && count_ok(alloc_count);
  assign al_has_free = ~&al_vld;

  always_comb begin
    if (al_hit)           al_way = al_hit_way;
    else if (al_has_free) al_way = first_free(~al_vld);
    else                  al_way = al_victim;
  end

  tsc_plru_bank #(.SETS(SETS), .IDX_W(IDX_W)) u_plru (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .a_en      (lk_hit),
    .a_idx     (lk_idx),
    .a_way     (lk_way),
    .b_en      (al_ok),
    .b_idx     (al_idx),
    .b_way     (al_way),
    .rd_idx    (al_idx),
    .rd_victim (al_victim)
  );

  // Registered response
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_hit   <= 1'b0;
      rsp_count <= '0;
      rsp_words <= '0;
    end else begin
      rsp_hit   <= lk_hit;
      rsp_count <= lk_hit ? lk_cnt[lk_way] : '0;
      rsp_words <= lk_hit ? keep_lanes(lk_data[lk_way], lk_cnt[lk_way]) : '0;
    end
  end

  // R2: no lookup, no hit in the following cycle
  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |=> !rsp_hit);

  // R3: a hit always carries a count from one to four
  p_count_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> (rsp_count >= 3'd1 && rsp_count <= 3'd4));

  // R4: a miss drives an all-zero response
  p_miss_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_hit |-> (rsp_count == '0 && rsp_words == '0));

  // R8: a lookup made while flushing misses
  p_flush_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !rsp_hit);

  // R5: a fresh tag goes into an invalid way while one exists
  p_fill_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (al_ok && !al_hit && al_has_free) |-> !al_vld[al_way]);

endmodule

// File: tb/tgt_stream_cache_tb.sv
`timescale 1ns/1ps
module tgt_stream_cache_tb_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         lkp_valid = 1'b0;
  logic [31:0]  lkp_addr = '0;
  logic         rsp_hit;
  logic [2:0]   rsp_count;
  logic [127:0] rsp_words;
  logic         alloc_valid = 1'b0;
  logic [31:0]  alloc_addr = '0;
  logic [127:0] alloc_words = '0;
  logic [2:0]   alloc_count = '0;
  logic         flush = 1'b0;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  always #2 clk = ~clk;

  tgt_stream_cache dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .lkp_valid   (lkp_valid),
    .lkp_addr    (lkp_addr),
    .rsp_hit     (rsp_hit),
    .rsp_count   (rsp_count),
    .rsp_words   (rsp_words),
    .alloc_valid (alloc_valid),
    .alloc_addr  (alloc_addr),
    .alloc_words (alloc_words),
    .alloc_count (alloc_count),
    .flush       (flush)
  );

  // Address from tag (bits 31:7) and set (bits 6:2)
  function automatic logic [31:0] mk_addr(int tag, int set);
    return (32'(tag) << 7) | (32'(set & 31) << 2);
  endfunction

  function automatic logic [127:0] pat(int s);
    return {32'(s + 3), 32'(s + 2), 32'(s + 1), 32'(s)};
  endfunction

  // Expected output lanes per R3
  function automatic logic [127:0] exp_words(int s, int cnt);
    logic [127:0] full, r;
    full = pat(s);
    r = '0;
    for (int l = 0; l < cnt; l++) r[l*32 +: 32] = full[l*32 +: 32];
    return r;
  endfunction

  task automatic chk(string req, string what, logic [127:0] act, logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic do_lookup(input logic [31:0] a, output logic h,
                           output logic [2:0] c, output logic [127:0] d);
    @(negedge clk);
    lkp_valid = 1'b1;
    lkp_addr  = a;
    @(negedge clk);
    lkp_valid = 1'b0;
    h = rsp_hit;
    c = rsp_count;
    d = rsp_words;
  endtask

  task automatic do_alloc(input logic [31:0] a, input int s, input int cnt);
    @(negedge clk);
    alloc_valid = 1'b1;
    alloc_addr  = a;
    alloc_words = pat(s);
    alloc_count = 3'(cnt);
    @(negedge clk);
    alloc_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic expect_hit(string req, logic [31:0] a, int s, int cnt);
    logic h; logic [2:0] c; logic [127:0] d;
    do_lookup(a, h, c, d);
    chk(req, "hit", 128'(h), 128'(1));
    chk(req, "count", 128'(c), 128'(cnt));
    chk(req, "words", d, exp_words(s, cnt));
  endtask

  task automatic expect_miss(string req, logic [31:0] a);
    logic h; logic [2:0] c; logic [127:0] d;
    do_lookup(a, h, c, d);
    chk(req, "hit", 128'(h), 128'(0));
    chk(req, "count", 128'(c), 128'(0));
    chk(req, "words", d, 128'(0));
  endtask

  task automatic t_reset_state();
    chk("R2", "idle hit after reset", 128'(rsp_hit), 128'(0));
    expect_miss("R4", mk_addr(1, 3));
  endtask

  task automatic t_basic_hit();
    do_alloc(mk_addr(5, 3), 100, 4);
    expect_hit("R3", mk_addr(5, 3), 100, 4);
    expect_hit("R1", mk_addr(5, 3) | 32'd2, 100, 4);
    expect_miss("R4", mk_addr(6, 3));
    expect_miss("R1", mk_addr(5, 4));
    @(negedge clk);
    chk("R2", "hit without lookup", 128'(rsp_hit), 128'(0));
  endtask

  task automatic t_partial();
    do_alloc(mk_addr(7, 9), 200, 2);
    expect_hit("R3", mk_addr(7, 9), 200, 2);
    do_alloc(mk_addr(9, 9), 250, 1);
    expect_hit("R3", mk_addr(9, 9), 250, 1);
  endtask

  task automatic t_bad_count();
    do_alloc(mk_addr(8, 10), 300, 0);
    expect_miss("R9", mk_addr(8, 10));
    do_alloc(mk_addr(8, 10), 300, 5);
    expect_miss("R9", mk_addr(8, 10));
  endtask

  task automatic t_flush();
    logic h; logic [2:0] c; logic [127:0] d;
    do_alloc(mk_addr(11, 1), 400, 4);
    do_flush();
    expect_miss("R8", mk_addr(11, 1));
    // allocation during flush is dropped
    @(negedge clk);
    flush = 1'b1; alloc_valid = 1'b1; alloc_addr = mk_addr(12, 2);
    alloc_words = pat(500); alloc_count = 3'd4;
    @(negedge clk);
    flush = 1'b0; alloc_valid = 1'b0;
    expect_miss("R8", mk_addr(12, 2));
    // lookup during flush misses
    do_alloc(mk_addr(13, 2), 600, 4);
    @(negedge clk);
    flush = 1'b1; lkp_valid = 1'b1; lkp_addr = mk_addr(13, 2);
    @(negedge clk);
    flush = 1'b0; lkp_valid = 1'b0;
    h = rsp_hit; c = rsp_count; d = rsp_words;
    chk("R8", "lookup in flush cycle", 128'(h), 128'(0));
  endtask

  task automatic t_same_cycle();
    do_flush();
    @(negedge clk);
    alloc_valid = 1'b1; alloc_addr = mk_addr(14, 6);
    alloc_words = pat(700); alloc_count = 3'd3;
    lkp_valid = 1'b1; lkp_addr = mk_addr(14, 6);
    @(negedge clk);
    alloc_valid = 1'b0; lkp_valid = 1'b0;
    chk("R10", "same-cycle lookup", 128'(rsp_hit), 128'(0));
    expect_hit("R10", mk_addr(14, 6), 700, 3);
  endtask

  task automatic t_evict_lru();
    do_flush();
    for (int t = 20; t < 24; t++) do_alloc(mk_addr(t, 12), t * 16, 4);
    // tree bits now 000, victim is way 0 holding tag 20
    do_alloc(mk_addr(24, 12), 24 * 16, 4);
    expect_miss("R7", mk_addr(20, 12));
    for (int t = 21; t < 25; t++) expect_hit("R5", mk_addr(t, 12), t * 16, 4);
  endtask

  task automatic t_hit_touch();
    do_flush();
    for (int t = 20; t < 24; t++) do_alloc(mk_addr(t, 13), t * 16, 4);
    expect_hit("R7", mk_addr(20, 13), 320, 4);
    // hit on way 0 sets b0=1, b2=0 -> victim way 2 (tag 22)
    do_alloc(mk_addr(24, 13), 24 * 16, 4);
    expect_miss("R7", mk_addr(22, 13));
    expect_hit("R7", mk_addr(20, 13), 320, 4);
    expect_hit("R7", mk_addr(24, 13), 384, 4);
  endtask

  task automatic t_overwrite();
    do_flush();
    do_alloc(mk_addr(30, 14), 800, 4);
    do_alloc(mk_addr(30, 14), 900, 3);
    expect_hit("R5", mk_addr(30, 14), 900, 3);
    for (int t = 31; t < 34; t++) do_alloc(mk_addr(t, 14), t * 16, 4);
    expect_hit("R6", mk_addr(30, 14), 900, 3);
    for (int t = 31; t < 34; t++) expect_hit("R6", mk_addr(t, 14), t * 16, 4);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_basic_hit();
    t_partial();
    t_bad_count();
    t_flush();
    t_same_cycle();
    t_evict_lru();
    t_hit_touch();
    t_overwrite();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule